// File: doc/BRIEF.md
# Chip-Select Decoder with Wait-State Generator

This block sits between a bus master and a group of external memory regions. Each region is described by a configuration word and a timing word, and the block keeps a copy of each. A copy is captured only when its load strobe is pulsed, and a region is unusable until that first capture. When a read or write request arrives, the address is compared against every valid, enabled region using a shared region mask. The lowest-numbered region that matches is selected and its chip-enable line is raised.

A wait counter is then loaded with a delay that depends on the region's memory type and on the packed timing subfields. The acknowledge is pulsed once the delay has run out. An address that matches no region gets a one-cycle error response. While a transfer or an error response is in progress the block reports busy and ignores new requests. The block does not drive any memory-device control pins.

Configuration word fields: bit 0 is the enable, bits [2:1] are the memory type, and bits [23:16] are the 8-bit region select. Memory type codes: 0 is SDRAM, 1 is synchronous SRAM, 2 is asynchronous memory, and 3 is generic synchronous memory.

Top module: `chip_sel_wait`

## Requirements
- R1: After reset, cs_en, busy, ack and err are all 0, and every region is invalid. A request made before any region is loaded gets an error response.
- R2: Region i matches when it has been loaded and its enable bit is 1, and (addr & (region_mask << 22)) == (select << 22). The whole 8-bit select field takes part in the compare.
- R3: When several regions match, the lowest-numbered one is the only one selected.
- R4: When no region matches, err is high for exactly one cycle, starting one rising edge after the request is accepted. No cs_en bit and no ack is raised for that request.
- R5: For asynchronous memory (type 2), the read delay is timing[7:0] + timing[11:8].
- R6: For asynchronous memory, the write delay is timing[15:12] + timing[19:16] + timing[25:20].
- R7: For SDRAM (type 0), the read delay and the write delay are both 3 + timing[5:4].
- R8: For synchronous SRAM (type 1) and generic synchronous memory (type 3), the read delay and the write delay are both 2.
- R9: A request is accepted on a rising edge while the block is idle. From the next edge on, cs_en is one-hot for the selected region and busy is 1. For a delay D, ack is high for exactly one cycle, starting D+1 rising edges after the accepting edge. After that cycle cs_en, busy and ack return to 0.
- R10: Requests and address changes made while busy is 1 are ignored. Neither the selected region nor the acknowledge timing changes.
- R11: Changes on the configuration and timing inputs take effect only for the region whose load bit is pulsed.
- R12: When rd_req and wr_req are both high, the request is treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Request address |
| rd_req | input | 1 | Read request strobe |
| wr_req | input | 1 | Write request strobe |
| region_mask | input | 8 | Shared region mask, applied at address bit 22 |
| cfg_words | input | NUM_CS*32 | Configuration word per region, region i at bits [32i+31:32i] |
| tim_words | input | NUM_CS*32 | Timing word per region, same packing |
| cfg_load | input | NUM_CS | Per-region capture strobe |
| cs_en | output | NUM_CS | One-hot chip-enable |
| busy | output | 1 | Transfer or error response in progress |
| ack | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle no-match response |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a new request and a transfer still counting. The bench provokes this by holding the strobes high and changing the address on every cycle of a wait. It then judges that the selected chip-enable stays put and that the acknowledge lands exactly D+1 edges after the accepting edge. The second pair is address decoding and region priority. Regions with identical selects are loaded together, and the bench checks that only the lowest enabled index is raised. When that region is then disabled, the bench checks that the next index takes over with its own delay.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int WORD_W       = 32;
  localparam int SEL_W        = 8;
  localparam int REGION_SHIFT = 22;
  localparam int TIM_W        = 26;
  localparam int DLY_W        = 9;
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_TYPE_LO  = 1;
  localparam int CFG_SEL_LO   = 16;

  typedef enum logic [1:0] {
    MT_SDRAM = 2'd0,
    MT_SSRAM = 2'd1,
    MT_ASYNC = 2'd2,
    MT_SYNC  = 2'd3
  } mem_type_e;

  typedef struct packed {
    logic             en;
    mem_type_e        mtype;
    logic [SEL_W-1:0] sel;
  } cs_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2,
    ST_ERR  = 2'd3
  } wait_st_e;
endpackage

// File: rtl/csd_cfg_bank.sv
module csd_cfg_bank
  import csd_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CS*WORD_W-1:0] cfg_in,
  input  logic [NUM_CS*WORD_W-1:0] tim_in,
  input  logic [NUM_CS-1:0]        load,
  output cs_cfg_t [NUM_CS-1:0]     cfg_q,
  output logic [NUM_CS-1:0][TIM_W-1:0] tim_q,
  output logic [NUM_CS-1:0]        valid_q
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
    cs_cfg_t          cfg_d;
    logic [TIM_W-1:0] tim_d;

    always_comb begin
      cfg_d.en    = cfg_in[g*WORD_W + CFG_EN_BIT];
      cfg_d.mtype = mem_type_e'(cfg_in[g*WORD_W + CFG_TYPE_LO +: 2]);
      cfg_d.sel   = cfg_in[g*WORD_W + CFG_SEL_LO +: SEL_W];
      tim_d       = tim_in[g*WORD_W +: TIM_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g]   <= '0;
        tim_q[g]   <= '0;
        valid_q[g] <= 1'b0;
      end else if (load[g]) begin
        cfg_q[g]   <= cfg_d;
        tim_q[g]   <= tim_d;
        valid_q[g] <= 1'b1;
      end
    end

    AST_VALID_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_q[g]) |-> $past(load[g])); // R11
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !load[g] |=> ($stable(cfg_q[g]) && $stable(tim_q[g]))); // R11
  end

endmodule

// File: rtl/csd_match.sv
module csd_match
  import csd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [SEL_W-1:0]     region_mask,
  input  cs_cfg_t [NUM_CS-1:0] cfg_q,
  input  logic [NUM_CS-1:0]    valid_q,
  output logic [NUM_CS-1:0]    gnt,
  output logic                 hit
);

  logic [ADDR_W-1:0] mask_full;
  logic [NUM_CS-1:0] match;

  assign mask_full = ADDR_W'(region_mask) << REGION_SHIFT;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    logic [ADDR_W-1:0] cmp_full;
    assign cmp_full = ADDR_W'(cfg_q[g].sel) << REGION_SHIFT;
    assign match[g] = valid_q[g] && cfg_q[g].en && ((addr & mask_full) == cmp_full);
  end

  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (match[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
    hit = taken;
  end

  always_comb begin
    if (hit) AST_GNT_IN_MATCH: assert ((gnt & ~match) == '0); // R3
  end

endmodule

// File: rtl/csd_delay.sv
module csd_delay
  import csd_pkg::*;
(
  input  mem_type_e         mtype,
  input  logic [TIM_W-1:0]  tim,
  input  logic              is_wr,
  output logic [DLY_W-1:0]  dly
);

  logic [DLY_W-1:0] async_rd;
  logic [DLY_W-1:0] async_wr;
  logic [DLY_W-1:0] sdram_lat;

  always_comb begin
    async_rd  = DLY_W'(tim[7:0]) + DLY_W'(tim[11:8]);
    async_wr  = DLY_W'(tim[15:12]) + DLY_W'(tim[19:16]) + DLY_W'(tim[25:20]);
    sdram_lat = DLY_W'(3) + DLY_W'(tim[5:4]);
    unique case (mtype)
      MT_ASYNC: dly = is_wr ? async_wr : async_rd;
      MT_SDRAM: dly = sdram_lat;
      MT_SSRAM: dly = DLY_W'(2);
      MT_SYNC:  dly = DLY_W'(2);
      default:  dly = DLY_W'(2);
    endcase
  end

endmodule

// File: rtl/csd_wait_fsm.sv
module csd_wait_fsm
  import csd_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hit,
  input  logic [NUM_CS-1:0] gnt,
  input  logic [DLY_W-1:0]  dly,
  output logic [NUM_CS-1:0] cs_en,
  output logic              busy,
  output logic              ack,
  output logic              err
);

  wait_st_e          st_q, st_d;
  logic [DLY_W-1:0]  cnt_q, cnt_d;
  logic [NUM_CS-1:0] cs_q, cs_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    cs_d  = cs_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (hit) begin
            st_d  = ST_WAIT;
            cnt_d = dly;
            cs_d  = gnt;
          end else begin
            st_d  = ST_ERR;
          end
        end
      end
      ST_WAIT: begin
        if (cnt_q == '0) st_d = ST_ACK;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_ACK: begin
        st_d = ST_IDLE;
        cs_d = '0;
      end
      ST_ERR:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      cs_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      cs_q  <= cs_d;
    end
  end

  assign cs_en = cs_q;
  assign busy  = (st_q != ST_IDLE);
  assign ack   = (st_q == ST_ACK);
  assign err   = (st_q == ST_ERR);

  AST_CS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_en)); // R3
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R9
  AST_ACK_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $onehot(cs_en)); // R9
  AST_ACK_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> ($past(cnt_q) == '0)); // R9
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err); // R4
  AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_en == '0 && !ack)); // R4
  AST_BUSY_HOLDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack && !err) |=> $stable(cs_en)); // R10

endmodule

// File: rtl/chip_sel_wait.sv
module chip_sel_wait
  import csd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     rd_req,
  input  logic                     wr_req,
  input  logic [SEL_W-1:0]         region_mask,
  input  logic [NUM_CS*WORD_W-1:0] cfg_words,
  input  logic [NUM_CS*WORD_W-1:0] tim_words,
  input  logic [NUM_CS-1:0]        cfg_load,
  output logic [NUM_CS-1:0]        cs_en,
  output logic                     busy,
  output logic                     ack,
  output logic                     err
);

  cs_cfg_t [NUM_CS-1:0]            cfg_q;
  logic [NUM_CS-1:0][TIM_W-1:0]    tim_q;
  logic [NUM_CS-1:0]               valid_q;
  logic [NUM_CS-1:0]               gnt;
  logic                            hit;
  logic                            start;
  logic                            is_wr;
  mem_type_e                       sel_type;
  logic [TIM_W-1:0]                sel_tim;
  logic [DLY_W-1:0]                dly;

  csd_cfg_bank #(.NUM_CS(NUM_CS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_in  (cfg_words),
    .tim_in  (tim_words),
    .load    (cfg_load),
    .cfg_q   (cfg_q),
    .tim_q   (tim_q),
    .valid_q (valid_q)
  );

  csd_match #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_match (
    .addr        (addr),
    .region_mask (region_mask),
    .cfg_q       (cfg_q),
    .valid_q     (valid_q),
    .gnt         (gnt),
    .hit         (hit)
  );

  always_comb begin
    logic [1:0] type_bits;
    type_bits = '0;
    sel_tim   = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (gnt[i]) begin
        type_bits = type_bits | cfg_q[i].mtype;
        sel_tim   = sel_tim | tim_q[i];
      end
    end
    sel_type = mem_type_e'(type_bits);
  end

  assign start = rd_req | wr_req;
  assign is_wr = wr_req & ~rd_req;

  csd_delay u_delay (
    .mtype (sel_type),
    .tim   (sel_tim),
    .is_wr (is_wr),
    .dly   (dly)
  );

  csd_wait_fsm #(.NUM_CS(NUM_CS)) u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .hit   (hit),
    .gnt   (gnt),
    .dly   (dly),
    .cs_en (cs_en),
    .busy  (busy),
    .ack   (ack),
    .err   (err)
  );

endmodule

// File: tb/chip_sel_wait_bench.sv
module chip_sel_wait_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;
  localparam int AW  = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [AW-1:0]   addr;
  logic            rd_req, wr_req;
  logic [7:0]      region_mask;
  logic [NCS*32-1:0] cfg_words, tim_words;
  logic [NCS-1:0]  cfg_load;
  logic [NCS-1:0]  cs_en;
  logic            busy, ack, err;

  logic [31:0] cfg_in [NCS];
  logic [31:0] tim_in [NCS];
  logic [31:0] m_cfg  [NCS];
  logic [31:0] m_tim  [NCS];
  bit          m_val  [NCS];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCS; i++) begin
      cfg_words[i*32 +: 32] = cfg_in[i];
      tim_words[i*32 +: 32] = tim_in[i];
    end
  end

  chip_sel_wait #(.NUM_CS(NCS), .ADDR_W(AW)) u_chip_sel_wait (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_req(rd_req), .wr_req(wr_req),
    .region_mask(region_mask), .cfg_words(cfg_words), .tim_words(tim_words),
    .cfg_load(cfg_load), .cs_en(cs_en), .busy(busy), .ack(ack), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(bit en, int mt, int sel);
    return (32'(sel & 8'hFF) << 16) | (32'(mt & 3) << 1) | 32'(en);
  endfunction

  function automatic int exp_delay(logic [31:0] c, logic [31:0] t, bit wr);
    case (c[2:1])
      2'd0: return 3 + int'(t[5:4]);
      2'd2: return wr ? int'(t[15:12]) + int'(t[19:16]) + int'(t[25:20])
                      : int'(t[7:0]) + int'(t[11:8]);
      default: return 2;
    endcase
  endfunction

  function automatic int exp_winner(logic [31:0] a);
    logic [31:0] mk;
    mk = {2'b00, region_mask, 22'b0};
    for (int i = 0; i < NCS; i++) begin
      if (m_val[i] && m_cfg[i][0] && ((a & mk) == {2'b00, m_cfg[i][23:16], 22'b0}))
        return i;
    end
    return -1;
  endfunction

  function automatic logic [31:0] mk_addr(logic [7:0] f);
    logic [31:0] a;
    a = $urandom;
    a[29:22] = f;
    return a;
  endfunction

  task automatic load_cs(input int i, input logic [31:0] c, input logic [31:0] t);
    @(negedge clk);
    cfg_in[i] = c;
    tim_in[i] = t;
    cfg_load[i] = 1'b1;
    @(negedge clk);
    cfg_load = '0;
    m_cfg[i] = c;
    m_tim[i] = t;
    m_val[i] = 1'b1;
  endtask

  task automatic run_txn(input logic [31:0] a, input bit rd, input bit wr,
                         input bit hold, input string req);
    int w, d, n;
    bit moved;
    logic [NCS-1:0] first_cs;
    w = exp_winner(a);
    @(negedge clk);
    addr = a; rd_req = rd; wr_req = wr;
    @(posedge clk);
    @(negedge clk);
    if (w < 0) begin
      chk(err == 1'b1, req, "R4 err after miss", int'(err), 1);
      chk(cs_en == '0 && ack == 1'b0, req, "R4 no cs/ack on miss", int'(cs_en), 0);
      rd_req = 0; wr_req = 0;
      @(negedge clk);
      chk(err == 1'b0 && busy == 1'b0, req, "R4 err one cycle", int'(err), 0);
    end else begin
      d = exp_delay(m_cfg[w], m_tim[w], wr && !rd);
      first_cs = cs_en;
      chk(cs_en == NCS'(1 << w), req, "R2/R3 selected cs_en", int'(cs_en), 1 << w);
      chk(busy == 1'b1, req, "R9 busy", int'(busy), 1);
      if (!hold) begin rd_req = 0; wr_req = 0; end
      n = 1;
      moved = 0;
      while (!ack && n < 400) begin
        if (hold) addr = $urandom;
        @(negedge clk);
        n++;
        if (cs_en != first_cs) moved = 1;
      end
      chk(!moved, req, "R10 cs_en held", int'(cs_en), int'(first_cs));
      chk(n - 1 == d + 1, req, "R9 ack edge count", n - 1, d + 1);
      rd_req = 0; wr_req = 0;
      @(negedge clk);
      chk(!ack && !busy && cs_en == '0, req, "R9 back to idle",
          int'({ack, busy, cs_en}), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_C5A1));
    rst_n = 1'b0;
    addr = '0; rd_req = 0; wr_req = 0; region_mask = 8'hFF; cfg_load = '0;
    for (int i = 0; i < NCS; i++) begin
      cfg_in[i] = '0; tim_in[i] = '0; m_cfg[i] = '0; m_tim[i] = '0; m_val[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(cs_en == '0 && !busy && !ack && !err, "R1", "reset outputs",
        int'({cs_en, busy, ack, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: nothing loaded yet, request gets an error
    run_txn(mk_addr(8'h01), 1, 0, 0, "R1");

    // R5 R6 R12: asynchronous region, read 10+5=15, write 3+4+6=13
    load_cs(0, mk_cfg(1, 2, 8'h01), {6'd0, 6'd6, 4'd4, 4'd3, 4'd5, 8'd10});
    run_txn(mk_addr(8'h01), 1, 0, 0, "R5");
    run_txn(mk_addr(8'h01), 0, 1, 0, "R6");
    run_txn(mk_addr(8'h01), 1, 1, 0, "R12");

    // R7: SDRAM 3 + timing[5:4]
    load_cs(1, mk_cfg(1, 0, 8'h02), 32'h0000_0030);
    run_txn(mk_addr(8'h02), 1, 0, 0, "R7");
    load_cs(1, mk_cfg(1, 0, 8'h02), 32'hFFFF_FF1F);
    run_txn(mk_addr(8'h02), 0, 1, 0, "R7");

    // R8: SSRAM and generic synchronous both 2
    load_cs(2, mk_cfg(1, 1, 8'h03), 32'hFFFF_FFFF);
    run_txn(mk_addr(8'h03), 1, 0, 0, "R8");
    load_cs(3, mk_cfg(1, 3, 8'h04), 32'hFFFF_FFFF);
    run_txn(mk_addr(8'h04), 0, 1, 0, "R8");

    // R3: cs1 and cs2 share a select, lowest wins; disable cs1, cs2 takes over
    load_cs(1, mk_cfg(1, 0, 8'h02), 32'h0000_0020);
    load_cs(2, mk_cfg(1, 1, 8'h02), 32'h0);
    run_txn(mk_addr(8'h02), 1, 0, 0, "R3");
    load_cs(1, mk_cfg(0, 0, 8'h02), 32'h0000_0020);
    run_txn(mk_addr(8'h02), 1, 0, 0, "R3");

    // R11: change cs2 inputs without load, old copy still in use
    @(negedge clk);
    cfg_in[2] = mk_cfg(0, 2, 8'h55);
    tim_in[2] = 32'hFFFF_FFFF;
    run_txn(mk_addr(8'h02), 0, 1, 0, "R11");

    // R5 R6: extreme asynchronous fields, read 270, write 93
    load_cs(0, mk_cfg(1, 2, 8'h01), 32'h03FF_FFFF);
    run_txn(mk_addr(8'h01), 1, 0, 0, "R5");
    run_txn(mk_addr(8'h01), 0, 1, 0, "R6");

    // R10: strobes held and address wandering while busy
    load_cs(0, mk_cfg(1, 2, 8'h01), {6'd0, 6'd1, 4'd1, 4'd1, 4'd2, 8'd7});
    run_txn(mk_addr(8'h01), 1, 0, 1, "R10");

    // R4: nothing matches
    run_txn(mk_addr(8'h7F), 1, 0, 0, "R4");

    // R2: partial mask
    region_mask = 8'hF0;
    load_cs(3, mk_cfg(1, 3, 8'h40), 32'h0);
    run_txn(mk_addr(8'h4F), 1, 0, 0, "R2");
    load_cs(3, mk_cfg(1, 3, 8'h41), 32'h0);
    run_txn(mk_addr(8'h41), 1, 0, 0, "R2");

    // random mix
    for (int t = 0; t < 200; t++) begin
      if (t % 8 == 0) begin
        load_cs($urandom_range(NCS - 1), mk_cfg(($urandom_range(3) != 0),
                $urandom_range(3), $urandom_range(255)), $urandom);
        region_mask = ($urandom_range(1) == 0) ? 8'hFF : 8'($urandom);
      end
      begin
        int k;
        logic [7:0] f;
        bit rd, wr;
        k = $urandom_range(NCS - 1);
        f = (m_cfg[k][23:16] & region_mask) | (8'($urandom) & ~region_mask);
        if ($urandom_range(7) == 0) f = 8'($urandom);
        rd = $urandom_range(1);
        wr = rd ? ($urandom_range(3) == 0) : 1'b1;
        run_txn(mk_addr(f), rd, wr, ($urandom_range(3) == 0), "R9");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule